// File: doc/BRIEF.md
# Push-Button Event Interrupt Logic

This block watches a synchronized push-button level, removes bounce with a tick-paced filter, and turns each committed change of the filtered level into a sticky event flag. A button press is a filtered fall from high to low. A button release is a filtered rise from low to high. Each kind of event has its own flag. Software clears a flag by writing a 1 to that flag's bit position. While either flag is set and the push-button interrupt mask is clear, the block drives an active-low, level-type interrupt request.

The block also shows the filtered button level as a real-time status bit. This bit never raises the interrupt. When the pin is not configured as a push-button, the filter follows the raw level with no events, the status bit reads 0 and neither flag can be set. Switching push-button mode on therefore never creates a spurious event. The filter length is set by the parameter `DEGL_TICKS`.

Top module: `pb_event_irq`

## Requirements
- R1: After synchronous reset, both flags read 0 and `irq_n` reads 1. The filtered level starts at 1 (released), so with `pb_mode`=1 `btn_status` reads 1.
- R2: The filtered level takes a new raw level only when the raw input has held that level unchanged for `DEGL_TICKS` clock edges with `tick`=1. The edge at which the change is first seen does not count. Any change of the raw level, or a return to the filtered value, restarts the count. Edges with `tick`=0 do not advance the count.
- R3: `btn_status` equals the filtered level (1 = released/high, 0 = pressed/low) while `pb_mode`=1, and reads 0 while `pb_mode`=0.
- R4: The press flag (`press_flag`, write-clear bit 0) is set at the edge where the filtered level commits from 1 to 0.
- R5: The release flag (`release_flag`, write-clear bit 1) is set at the edge where the filtered level commits from 0 to 1.
- R6: A write (`wr_en`=1) clears each flag whose `wr_data` bit is 1 (bit 0 = press, bit 1 = release) at the next edge. `wr_data` bits at 0 leave their flags unchanged.
- R7: If a flag's set event and a write-1 clear of that flag fall on the same edge, the flag ends up set.
- R8: `irq_n` is 0 exactly when `irq_mask`=0 and at least one flag is set. `btn_status` has no effect on `irq_n`.
- R9: While `pb_mode`=0, no flag is set and the filter follows the raw level. Turning `pb_mode` on while the raw level is steady creates no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_raw | input | 1 | Synchronized raw button level (1 = released) |
| pb_mode | input | 1 | Pin is configured as a push-button |
| irq_mask | input | 1 | 1 masks both event flags from the interrupt |
| tick | input | 1 | Time base enable for the filter count |
| wr_en | input | 1 | Flag-clear write strobe |
| wr_data | input | 2 | Write-1-to-clear bits: 0 = press, 1 = release |
| btn_status | output | 1 | Filtered real-time button level |
| press_flag | output | 1 | Sticky press event |
| release_flag | output | 1 | Sticky release event |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A filter commit that sets a flag can land on the same edge as a write-1 clear of that same flag. The bench provokes this by counting filter edges from the raw change and raising the clear write one cycle before the commit edge. Afterwards the flag must read 1, while the other flag, cleared in the same write with no event of its own, reads 0. The random phase makes such collisions many more times, and the per-cycle reference model judges every one with the rule that the set wins.

// File: rtl/pbirq_pkg.sv
package pbirq_pkg;

    localparam int NUM_FLAGS   = 2;
    localparam int PRESS_BIT   = 0;
    localparam int RELEASE_BIT = 1;

    // one bit per event kind; packed order matches the write-clear bits
    typedef struct packed {
        logic rel;
        logic press;
    } evt_t;

    function automatic logic irq_active(input evt_t f, input logic mask);
        return !mask && (f.press || f.rel);
    endfunction

    function automatic evt_t clr_vec(input logic en, input logic [NUM_FLAGS-1:0] bits);
        evt_t c;
        c.press = en && bits[PRESS_BIT];
        c.rel   = en && bits[RELEASE_BIT];
        return c;
    endfunction

endpackage

// File: rtl/pb_deglitch.sv
module pb_deglitch
    import pbirq_pkg::*;
#(
    parameter int DEGL_TICKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    input  logic pb_mode,
    input  logic tick,
    output logic level,
    output evt_t evt
);
    localparam int CNT_W = (DEGL_TICKS > 1) ? $clog2(DEGL_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DEGL_TICKS - 1);

    logic             raw_q;
    logic             filt;
    logic [CNT_W-1:0] cnt;
    logic             steady;
    logic             commit;

    always_comb begin
        steady    = (raw == raw_q) && (raw != filt);
        commit    = pb_mode && steady && tick && (cnt == LAST);
        evt.press = commit && !raw;
        evt.rel   = commit && raw;
        level     = filt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q <= 1'b1;
            filt  <= 1'b1;
            cnt   <= '0;
        end else begin
            raw_q <= raw;
            if (!pb_mode) begin
                filt <= raw;
                cnt  <= '0;
            end else if (!steady) begin
                cnt <= '0;
            end else if (tick) begin
                if (cnt == LAST) begin
                    filt <= raw;
                    cnt  <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R2: without a tick the filtered level cannot move in push-button mode
    assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (rst)
        (pb_mode && !tick) |=> $stable(filt));

    // R2: a fresh raw change never commits on the edge that sees it
    assert_restart_on_change_R2: assert property (@(posedge clk) disable iff (rst)
        (pb_mode && (raw != raw_q)) |=> $stable(filt));

    // R2: counter never passes its terminal value
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

endmodule

// File: rtl/pb_event_flags.sv
module pb_event_flags
    import pbirq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  evt_t                 set_evt,
    input  logic                 wr_en,
    input  logic [NUM_FLAGS-1:0] wr_data,
    output evt_t                 flags
);
    evt_t clr;

    always_comb clr = clr_vec(wr_en, wr_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags.press <= set_evt.press || (flags.press && !clr.press);
            flags.rel   <= set_evt.rel   || (flags.rel   && !clr.rel);
        end
    end

    // R7: set beats a simultaneous clear
    assert_set_wins_press_R7: assert property (@(posedge clk) disable iff (rst)
        (set_evt.press && wr_en && wr_data[PRESS_BIT]) |=> flags.press);
    assert_set_wins_rel_R7: assert property (@(posedge clk) disable iff (rst)
        (set_evt.rel && wr_en && wr_data[RELEASE_BIT]) |=> flags.rel);

    // R6: write-1 clears when no event competes
    assert_w1c_press_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[PRESS_BIT] && !set_evt.press) |=> !flags.press);

    // R6: a set flag stays set unless its clear bit is written as 1
    assert_sticky_rel_R6: assert property (@(posedge clk) disable iff (rst)
        (flags.rel && !(wr_en && wr_data[RELEASE_BIT])) |=> flags.rel);

endmodule

// File: rtl/pb_event_irq.sv
module pb_event_irq
    import pbirq_pkg::*;
#(
    parameter int DEGL_TICKS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       btn_raw,
    input  logic       pb_mode,
    input  logic       irq_mask,
    input  logic       tick,
    input  logic       wr_en,
    input  logic [1:0] wr_data,
    output logic       btn_status,
    output logic       press_flag,
    output logic       release_flag,
    output logic       irq_n
);
    logic level;
    evt_t evt;
    evt_t flags;

    pb_deglitch #(.DEGL_TICKS(DEGL_TICKS)) u_filter (
        .clk     (clk),
        .rst     (rst),
        .raw     (btn_raw),
        .pb_mode (pb_mode),
        .tick    (tick),
        .level   (level),
        .evt     (evt)
    );

    pb_event_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_evt (evt),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .flags   (flags)
    );

    always_comb begin
        btn_status   = pb_mode && level;
        press_flag   = flags.press;
        release_flag = flags.rel;
        irq_n        = !irq_active(flags, irq_mask);
    end

    // R8: the mask silences the request whatever the flags hold
    assert_mask_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        irq_mask |-> irq_n);

    // R8: with no flag set the request is idle, status level notwithstanding
    assert_no_flag_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (!press_flag && !release_flag) |-> irq_n);

    // R9: outside push-button mode no flag can become set
    assert_mode_off_press_R9: assert property (@(posedge clk) disable iff (rst)
        (!pb_mode && !press_flag) |=> !press_flag);
    assert_mode_off_rel_R9: assert property (@(posedge clk) disable iff (rst)
        (!pb_mode && !release_flag) |=> !release_flag);

endmodule

// File: tb/pb_event_irq_tb.sv
`timescale 1ns/1ps
module pb_event_irq_tb;
    localparam int D = 4;

    logic clk = 1'b0;
    logic rst, btn_raw, pb_mode, irq_mask, tick, wr_en;
    logic [1:0] wr_data;
    logic btn_status, press_flag, release_flag, irq_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // behavioural reference state
    int m_filt, m_cnt, m_rawq, m_press, m_rel;
    bit m_valid = 0;

    always #10 clk = ~clk;

    pb_event_irq #(.DEGL_TICKS(D)) u_dut (
        .clk(clk), .rst(rst), .btn_raw(btn_raw), .pb_mode(pb_mode),
        .irq_mask(irq_mask), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
        .btn_status(btn_status), .press_flag(press_flag),
        .release_flag(release_flag), .irq_n(irq_n)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // reference model: advance at each edge, compare shortly after
    always @(posedge clk) begin
        int fe, re;
        fe = 0; re = 0;
        if (rst) begin
            m_filt = 1; m_cnt = 0; m_rawq = 1; m_press = 0; m_rel = 0;
            m_valid = 1;
        end else if (m_valid) begin
            if (!pb_mode) begin
                m_filt = btn_raw; m_cnt = 0;
            end else if (btn_raw != m_rawq || btn_raw == m_filt) begin
                m_cnt = 0;
            end else if (tick) begin
                m_cnt = m_cnt + 1;
                if (m_cnt == D) begin
                    m_filt = btn_raw; m_cnt = 0;
                    fe = (btn_raw == 0); re = (btn_raw == 1);
                end
            end
            m_rawq = btn_raw;
            m_press = fe | (m_press & !(wr_en & wr_data[0]));
            m_rel   = re | (m_rel   & !(wr_en & wr_data[1]));
        end
        #5;
        if (m_valid && !done) begin
            check("R3 status", btn_status, logic'(pb_mode ? m_filt[0] : 1'b0));
            check("R4 press", press_flag, logic'(m_press[0]));
            check("R5 release", release_flag, logic'(m_rel[0]));
            check("R8 irq_n", irq_n, logic'(!(!irq_mask && (m_press != 0 || m_rel != 0))));
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1; btn_raw = 1; pb_mode = 1; irq_mask = 0; tick = 1;
        wr_en = 0; wr_data = 2'b00;
        step(3); rst = 0; step(1);
        // R1 reset state
        check("R1 press", press_flag, 1'b0);
        check("R1 release", release_flag, 1'b0);
        check("R1 irq_n", irq_n, 1'b1);
        check("R1 status", btn_status, 1'b1);

        // R2 filter length, R4 press, R8 request
        btn_raw = 0; step(D);
        check("R2 not yet", btn_status, 1'b1);
        step(1);
        check("R2 commit", btn_status, 1'b0);
        check("R4 press set", press_flag, 1'b1);
        check("R8 irq low", irq_n, 1'b0);

        // R2 glitch shorter than the filter
        btn_raw = 1; step(2); btn_raw = 0; step(D + 2);
        check("R2 glitch ignored", release_flag, 1'b0);

        // R6 zero bits do nothing, one bit clears
        wr_en = 1; wr_data = 2'b00; step(1); wr_en = 0;
        check("R6 zero write", press_flag, 1'b1);
        wr_en = 1; wr_data = 2'b01; step(1); wr_en = 0;
        check("R6 clear press", press_flag, 1'b0);
        check("R8 irq idle", irq_n, 1'b1);

        // R5 release
        btn_raw = 1; step(D + 1);
        check("R5 release set", release_flag, 1'b1);
        btn_raw = 0; step(D + 1);
        check("R4 press again", press_flag, 1'b1);

        // R7 clear on the commit edge of a release
        btn_raw = 1; step(D);
        wr_en = 1; wr_data = 2'b11; step(1); wr_en = 0; wr_data = 2'b00;
        check("R7 set wins", release_flag, 1'b1);
        check("R6 press cleared", press_flag, 1'b0);

        // R8 mask
        irq_mask = 1; step(1);
        check("R8 masked", irq_n, 1'b1);
        irq_mask = 0; step(1);
        check("R8 unmasked", irq_n, 1'b0);
        wr_en = 1; wr_data = 2'b11; step(1); wr_en = 0; wr_data = 2'b00;

        // R9 mode off
        pb_mode = 0; step(1);
        check("R9 status zero", btn_status, 1'b0);
        btn_raw = 0; step(D + 4);
        check("R9 no press", press_flag, 1'b0);
        btn_raw = 1; step(D + 4);
        check("R9 no release", release_flag, 1'b0);
        btn_raw = 0; step(2); pb_mode = 1; step(D + 2);
        check("R9 enable no event", press_flag, 1'b0);
        check("R3 status low", btn_status, 1'b0);

        // R2 ticks pace the filter
        tick = 0; btn_raw = 1; step(10);
        check("R2 no tick hold", btn_status, 1'b0);
        tick = 1; step(D);
        check("R2 tick commit", btn_status, 1'b1);
        check("R5 after ticks", release_flag, 1'b1);

        // random phase, judged by the reference model
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 7 == 0) btn_raw = ~btn_raw;
            tick     = 1'($urandom % 3 != 0);
            wr_en    = 1'($urandom % 6 == 0);
            wr_data  = 2'($urandom);
            irq_mask = 1'($urandom % 5 == 0);
            if ($urandom % 300 == 0) pb_mode = ~pb_mode;
            step(1);
        end
        wr_en = 0; step(2);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule